// File: doc/BRIEF.md
# Resonant Half-Bridge Gate Timing Generator

This block produces the four gate drives of a resonant half-bridge converter that uses synchronous rectification. A single up-counter runs through a switching period whose length, in clock cycles, comes from a control input. A longer period gives a lower switching frequency. The first half of each period is the high-side phase and the second half is the low-side phase. The high-side and low-side gates form a complementary pair, and each has its own dead time before it turns on. One rectifier gate belongs to each phase. A rectifier turns on a programmable number of counts after its phase starts, and turns off a programmable number of counts before its phase ends.

An optional comparator mode lets each rectifier's current comparator hold its gate on past that early turn-off point. The gate stays on while the comparator reports current above threshold, and is always released at the boundary of its own phase. The control inputs are copied into working registers only at the last count of a period: the period length, both dead times, the rectifier margins and the three enables. A new setting therefore always starts on a clean period. A one-clock strobe marks the first count of each period, so the surrounding control loop can use it as its update trigger.

Top module: `hb_gate_timer`

## Requirements
- R1: The period length in clocks equals the period value latched at the previous boundary, and `pstart_o` is high for exactly one clock at the start of each period. A period is the span from one `pstart_o` cycle to the next.
- R2: Number the cycles of a period from 0, with the `pstart_o` cycle as 0, and let P be the period and H = floor(P/2). Then `hs_o` is high for positions [hs_delay, H) and `ls_o` is high for positions [H + ls_delay, P). The two are never high together.
- R3: With comparator mode off, `sr2_o` (high-side phase) is high for positions [sr2_lead, H - sr2_trail) and low elsewhere.
- R4: With comparator mode off, `sr1_o` (low-side phase) is high for positions [H + sr1_lead, P - sr1_trail) and low elsewhere.
- R5: With comparator mode on and a rectifier's comparator input held high, that rectifier stays on from its normal turn-off position up to the end of its phase: H for `sr2_o`, P for `sr1_o`. It never overlaps the opposite phase.
- R6: In comparator mode, suppose a comparator input is low during position j, where j is at or after the normal turn-off position. The rectifier is then off from position j+1 and stays off for the rest of the phase. It never turns off earlier than its normal turn-off position.
- R7: With comparator mode off, the comparator inputs have no effect on `sr1_o` or `sr2_o`.
- R8: If the bridge enable was low at the boundary, `hs_o` and `ls_o` stay low for that whole period. If the rectifier enable was low, `sr1_o` and `sr2_o` stay low. Each enable acts independently of the other.
- R9: Changing any input in the middle of a period has no effect on the current period; the new value takes effect from the next `pstart_o`.
- R10: During reset all outputs are low. The first period after reset lasts MIN_PERIOD clocks (default 8).
- R11: A period input below MIN_PERIOD is raised to MIN_PERIOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Switching period in clocks |
| hs_delay_i | input | DT_W | Dead time before high-side turn-on |
| ls_delay_i | input | DT_W | Dead time before low-side turn-on |
| sr1_lead_i | input | DT_W | Rectifier 1 turn-on delay after the low-side phase starts |
| sr1_trail_i | input | DT_W | Rectifier 1 turn-off advance before the period ends |
| sr2_lead_i | input | DT_W | Rectifier 2 turn-on delay after the period starts |
| sr2_trail_i | input | DT_W | Rectifier 2 turn-off advance before mid-period |
| bridge_en_i | input | 1 | Enables the half-bridge pair |
| rect_en_i | input | 1 | Enables both rectifier gates |
| cmp_mode_i | input | 1 | Enables the comparator-held turn-off |
| sr1_cmp_i | input | 1 | Rectifier 1 current above threshold |
| sr2_cmp_i | input | 1 | Rectifier 2 current above threshold |
| hs_o | output | 1 | High-side gate |
| ls_o | output | 1 | Low-side gate |
| sr1_o | output | 1 | Rectifier 1 gate (low-side phase) |
| sr2_o | output | 1 | Rectifier 2 gate (high-side phase) |
| pstart_o | output | 1 | One-clock strobe on the first count of a period |

## Verification
The hardest situation to reach is the comparator cutting off a rectifier partway through its extension window. The cut must land after the advanced turn-off point and before the phase boundary, and that boundary moves whenever the period changes. The stimulus handles this by aligning to the `pstart_o` strobe and counting positions from it. It drops both comparator inputs at one chosen position inside rectifier 2's extension window, and that same position falls before rectifier 1 has turned on. A single period therefore shows an extension that is cut short on one rectifier and no extension at all on the other. A second scenario changes the dead time and the period at a known position in the middle of a period, to show that the running period is untouched.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Enables latched together at each period boundary
  typedef struct packed {
    logic bridge;
    logic rect;
    logic cmp;
  } hbg_en_t;

  // Rectifier index: 0 conducts in the low-side phase, 1 in the high-side phase
  localparam int RECT_LOW  = 0;
  localparam int RECT_HIGH = 1;
  localparam int NUM_RECT  = 2;

endpackage

// File: rtl/hbg_period_ctr.sv
module hbg_period_ctr #(
  parameter int CNT_W      = 12,
  parameter int DT_W       = 8,
  parameter int MIN_PERIOD = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [CNT_W-1:0]                       period_i,
  input  logic [DT_W-1:0]                        hs_dly_i,
  input  logic [DT_W-1:0]                        ls_dly_i,
  input  logic [hbg_pkg::NUM_RECT-1:0][DT_W-1:0] lead_i,
  input  logic [hbg_pkg::NUM_RECT-1:0][DT_W-1:0] trail_i,
  input  hbg_pkg::hbg_en_t                       en_i,
  output logic [CNT_W-1:0]                       cnt_o,
  output logic [CNT_W-1:0]                       per_o,
  output logic [CNT_W-1:0]                       half_o,
  output logic [DT_W-1:0]                        hs_dly_o,
  output logic [DT_W-1:0]                        ls_dly_o,
  output logic [hbg_pkg::NUM_RECT-1:0][DT_W-1:0] lead_o,
  output logic [hbg_pkg::NUM_RECT-1:0][DT_W-1:0] trail_o,
  output hbg_pkg::hbg_en_t                       en_o,
  output logic                                   pstart_o
);
  localparam int NR = hbg_pkg::NUM_RECT;
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic [CNT_W-1:0]          per_q, per_in;
  logic [DT_W-1:0]           hs_dly_q, ls_dly_q;
  logic [NR-1:0][DT_W-1:0]   lead_q, trail_q;
  hbg_pkg::hbg_en_t          en_q;
  logic                      pstart_q, pstart_d;
  logic                      last_cnt;
  logic                      load_en;

  // next-state
  always_comb begin
    last_cnt = (cnt_q == (per_q - 1'b1));
    load_en  = last_cnt;
    cnt_d    = last_cnt ? '0 : (cnt_q + 1'b1);
    per_in   = (period_i < MIN_P) ? MIN_P : period_i;
    pstart_d = (cnt_q == '0);
  end

  // counter and strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      pstart_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      pstart_q <= pstart_d;
    end
  end

  // working copy of the settings, loaded only on the last count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q    <= MIN_P;
      hs_dly_q <= '0;
      ls_dly_q <= '0;
      lead_q   <= '0;
      trail_q  <= '0;
      en_q     <= '0;
    end else if (load_en) begin
      per_q    <= per_in;
      hs_dly_q <= hs_dly_i;
      ls_dly_q <= ls_dly_i;
      lead_q   <= lead_i;
      trail_q  <= trail_i;
      en_q     <= en_i;
    end
  end

  assign cnt_o    = cnt_q;
  assign per_o    = per_q;
  assign half_o   = per_q >> 1;
  assign hs_dly_o = hs_dly_q;
  assign ls_dly_o = ls_dly_q;
  assign lead_o   = lead_q;
  assign trail_o  = trail_q;
  assign en_o     = en_q;
  assign pstart_o = pstart_q;

endmodule

// File: rtl/hbg_bridge_dec.sv
module hbg_bridge_dec #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [DT_W-1:0]  hs_dly_i,
  input  logic [DT_W-1:0]  ls_dly_i,
  input  logic             en_i,
  output logic             hs_o,
  output logic             ls_o
);
  localparam int XW = CNT_W + 1;

  logic [XW-1:0] cnt_x, half_x, hs_on_x, ls_on_x;
  logic          hs_q, hs_d, ls_q, ls_d;

  always_comb begin
    cnt_x   = XW'(cnt_i);
    half_x  = XW'(half_i);
    hs_on_x = XW'(hs_dly_i);
    ls_on_x = half_x + XW'(ls_dly_i);
    hs_d    = en_i && (cnt_x >= hs_on_x) && (cnt_x < half_x);
    ls_d    = en_i && (cnt_x >= ls_on_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

endmodule

// File: rtl/hbg_rect_gate.sv
module hbg_rect_gate #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ph_lo_i,
  input  logic [CNT_W-1:0] ph_hi_i,
  input  logic [DT_W-1:0]  lead_i,
  input  logic [DT_W-1:0]  trail_i,
  input  logic             en_i,
  input  logic             cmp_mode_i,
  input  logic             cmp_i,
  output logic             gate_o
);
  localparam int XW = CNT_W + 1;

  logic [XW-1:0] cnt_x, lo_x, hi_x, on_x;
  logic          in_phase, base_win, hold_win;
  logic          gate_q, gate_d;

  always_comb begin
    cnt_x    = XW'(cnt_i);
    lo_x     = XW'(ph_lo_i);
    hi_x     = XW'(ph_hi_i);
    on_x     = lo_x + XW'(lead_i);
    in_phase = (cnt_x >= lo_x) && (cnt_x < hi_x);
    // nominal window: delayed start, advanced end
    base_win = (cnt_x >= on_x) && ((cnt_x + XW'(trail_i)) < hi_x);
    // extension: only continues an already-on gate, never past the phase end
    hold_win = in_phase && cmp_mode_i && cmp_i && gate_q;
    gate_d   = en_i && (base_win || hold_win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/hb_gate_timer.sv
module hb_gate_timer #(
  parameter int CNT_W      = 12,
  parameter int DT_W       = 8,
  parameter int MIN_PERIOD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [DT_W-1:0]  hs_delay_i,
  input  logic [DT_W-1:0]  ls_delay_i,
  input  logic [DT_W-1:0]  sr1_lead_i,
  input  logic [DT_W-1:0]  sr1_trail_i,
  input  logic [DT_W-1:0]  sr2_lead_i,
  input  logic [DT_W-1:0]  sr2_trail_i,
  input  logic             bridge_en_i,
  input  logic             rect_en_i,
  input  logic             cmp_mode_i,
  input  logic             sr1_cmp_i,
  input  logic             sr2_cmp_i,
  output logic             hs_o,
  output logic             ls_o,
  output logic             sr1_o,
  output logic             sr2_o,
  output logic             pstart_o
);
  localparam int NR = hbg_pkg::NUM_RECT;

  logic [CNT_W-1:0]        cnt, per, half;
  logic [DT_W-1:0]         hs_dly, ls_dly;
  logic [NR-1:0][DT_W-1:0] lead_in, trail_in, lead, trail;
  logic [NR-1:0][CNT_W-1:0] ph_lo, ph_hi;
  logic [NR-1:0]           cmp_v, gate_v;
  hbg_pkg::hbg_en_t        en_in, en_q;

  always_comb begin
    en_in.bridge = bridge_en_i;
    en_in.rect   = rect_en_i;
    en_in.cmp    = cmp_mode_i;
    lead_in[hbg_pkg::RECT_LOW]   = sr1_lead_i;
    lead_in[hbg_pkg::RECT_HIGH]  = sr2_lead_i;
    trail_in[hbg_pkg::RECT_LOW]  = sr1_trail_i;
    trail_in[hbg_pkg::RECT_HIGH] = sr2_trail_i;
    cmp_v[hbg_pkg::RECT_LOW]     = sr1_cmp_i;
    cmp_v[hbg_pkg::RECT_HIGH]    = sr2_cmp_i;
    ph_lo[hbg_pkg::RECT_LOW]     = half;
    ph_hi[hbg_pkg::RECT_LOW]     = per;
    ph_lo[hbg_pkg::RECT_HIGH]    = '0;
    ph_hi[hbg_pkg::RECT_HIGH]    = half;
  end

  hbg_period_ctr #(
    .CNT_W(CNT_W), .DT_W(DT_W), .MIN_PERIOD(MIN_PERIOD)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .period_i(period_i), .hs_dly_i(hs_delay_i), .ls_dly_i(ls_delay_i),
    .lead_i(lead_in), .trail_i(trail_in), .en_i(en_in),
    .cnt_o(cnt), .per_o(per), .half_o(half),
    .hs_dly_o(hs_dly), .ls_dly_o(ls_dly),
    .lead_o(lead), .trail_o(trail), .en_o(en_q),
    .pstart_o(pstart_o)
  );

  hbg_bridge_dec #(.CNT_W(CNT_W), .DT_W(DT_W)) u_bridge (
    .clk(clk), .rst_n(rst_n),
    .cnt_i(cnt), .half_i(half),
    .hs_dly_i(hs_dly), .ls_dly_i(ls_dly),
    .en_i(en_q.bridge),
    .hs_o(hs_o), .ls_o(ls_o)
  );

  for (genvar r = 0; r < NR; r++) begin : g_rect
    hbg_rect_gate #(.CNT_W(CNT_W), .DT_W(DT_W)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .cnt_i(cnt), .ph_lo_i(ph_lo[r]), .ph_hi_i(ph_hi[r]),
      .lead_i(lead[r]), .trail_i(trail[r]),
      .en_i(en_q.rect), .cmp_mode_i(en_q.cmp), .cmp_i(cmp_v[r]),
      .gate_o(gate_v[r])
    );
  end

  assign sr1_o = gate_v[hbg_pkg::RECT_LOW];
  assign sr2_o = gate_v[hbg_pkg::RECT_HIGH];

endmodule

// File: rtl/hb_gate_timer_chk.sv
module hb_gate_timer_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             hs_o,
  input logic             ls_o,
  input logic             sr1_o,
  input logic             sr2_o,
  input logic             pstart_o,
  input hbg_pkg::hbg_en_t en_cur
);

  AST_PSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pstart_o |=> !pstart_o); // R1

  AST_BRIDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_o && ls_o)); // R2

  AST_PSTART_LOW_PHASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pstart_o |-> (!ls_o && !sr1_o)); // R2

  AST_RECT_PHASE_SEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr1_o && hs_o) && !(sr2_o && ls_o) && !(sr1_o && sr2_o)); // R5

  AST_BRIDGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_cur.bridge |=> (!hs_o && !ls_o)); // R8

  AST_RECT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_cur.rect |=> (!sr1_o && !sr2_o)); // R8

endmodule

bind hb_gate_timer hb_gate_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .hs_o(hs_o), .ls_o(ls_o), .sr1_o(sr1_o), .sr2_o(sr2_o),
  .pstart_o(pstart_o), .en_cur(en_q)
);

// File: tb/hb_gate_timer_tb_top.sv
module hb_gate_timer_tb_top;
  localparam int CLK_NS = 10;
  localparam int CNT_W  = 12;
  localparam int DT_W   = 8;

  logic clk, rst_n;
  logic [CNT_W-1:0] period;
  logic [DT_W-1:0]  hs_dly, ls_dly, sr1_lead, sr1_trail, sr2_lead, sr2_trail;
  logic bridge_en, rect_en, cmp_mode, sr1_cmp, sr2_cmp;
  logic hs_o, ls_o, sr1_o, sr2_o, pstart_o;

  int n_run, n_fail, cap_len;
  logic [255:0] cap_hs, cap_ls, cap_sr1, cap_sr2;

  hb_gate_timer #(.CNT_W(CNT_W), .DT_W(DT_W), .MIN_PERIOD(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_i(period),
    .hs_delay_i(hs_dly), .ls_delay_i(ls_dly),
    .sr1_lead_i(sr1_lead), .sr1_trail_i(sr1_trail),
    .sr2_lead_i(sr2_lead), .sr2_trail_i(sr2_trail),
    .bridge_en_i(bridge_en), .rect_en_i(rect_en), .cmp_mode_i(cmp_mode),
    .sr1_cmp_i(sr1_cmp), .sr2_cmp_i(sr2_cmp),
    .hs_o(hs_o), .ls_o(ls_o), .sr1_o(sr1_o), .sr2_o(sr2_o), .pstart_o(pstart_o)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic win(input string req, input string nm, input logic [255:0] v,
                     input int lo, input int hi);
    int bad = -1;
    for (int k = 0; k < cap_len; k++) begin
      if (v[k] !== ((k >= lo) && (k < hi)) && bad < 0) bad = k;
    end
    n_run++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s %s at position %0d: actual %0b expected %0b",
               req, nm, bad, v[bad], ((bad >= lo) && (bad < hi)));
    end
  endtask

  // records one full period, position 0 being the pstart cycle
  task automatic capture(input int drop_pos, input int chg_pos);
    int guard = 0;
    int k = 0;
    cap_hs = '0; cap_ls = '0; cap_sr1 = '0; cap_sr2 = '0;
    @(negedge clk);
    while (pstart_o !== 1'b1 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    do begin
      cap_hs[k] = hs_o; cap_ls[k] = ls_o; cap_sr1[k] = sr1_o; cap_sr2[k] = sr2_o;
      if (k == drop_pos) begin sr1_cmp = 1'b0; sr2_cmp = 1'b0; end
      if (k == chg_pos)  begin hs_dly = 8'd7; period = 12'd50; end
      @(negedge clk);
      k++;
    end while (pstart_o !== 1'b1 && k < 256);
    cap_len = k;
  endtask

  task automatic base_cfg();
    period = 12'd40; hs_dly = 8'd2; ls_dly = 8'd3;
    sr2_lead = 8'd1; sr2_trail = 8'd2; sr1_lead = 8'd4; sr1_trail = 8'd3;
    bridge_en = 1'b1; rect_en = 1'b1; cmp_mode = 1'b0;
    sr1_cmp = 1'b0; sr2_cmp = 1'b0;
  endtask

  task automatic t_reset();
    int n = 0;
    int guard = 0;
    base_cfg();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "outputs in reset", {hs_o, ls_o, sr1_o, sr2_o, pstart_o}, 0);
    rst_n = 1'b1;
    while (pstart_o !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    do begin @(negedge clk); n++; end while (pstart_o !== 1'b1 && n < 200);
    check("R10", "first period length", n, 8);
  endtask

  task automatic t_basic();
    base_cfg();
    capture(-1, -1);
    check("R1", "period 40 length", cap_len, 40);
    win("R2", "hs P40", cap_hs, 2, 20);
    win("R2", "ls P40", cap_ls, 23, 40);
    win("R3", "sr2 P40", cap_sr2, 1, 18);
    win("R4", "sr1 P40", cap_sr1, 24, 37);
  endtask

  task automatic t_odd();
    base_cfg(); period = 12'd41;
    capture(-1, -1);
    check("R1", "period 41 length", cap_len, 41);
    win("R2", "hs P41", cap_hs, 2, 20);
    win("R2", "ls P41", cap_ls, 23, 41);
    win("R4", "sr1 P41", cap_sr1, 24, 38);
  endtask

  task automatic t_cmp_ignored();
    base_cfg(); sr1_cmp = 1'b1; sr2_cmp = 1'b1;
    capture(-1, -1);
    win("R7", "sr2 cmp mode off", cap_sr2, 1, 18);
    win("R7", "sr1 cmp mode off", cap_sr1, 24, 37);
  endtask

  task automatic t_cmp_hold();
    base_cfg(); cmp_mode = 1'b1; sr1_cmp = 1'b1; sr2_cmp = 1'b1;
    capture(-1, -1);
    win("R5", "sr2 held to mid", cap_sr2, 1, 20);
    win("R5", "sr1 held to end", cap_sr1, 24, 40);
    win("R2", "hs unaffected", cap_hs, 2, 20);
  endtask

  task automatic t_cmp_drop();
    base_cfg(); cmp_mode = 1'b1; sr2_trail = 8'd6; sr1_cmp = 1'b1; sr2_cmp = 1'b1;
    capture(16, -1);
    win("R6", "sr2 cut after drop", cap_sr2, 1, 17);
    win("R6", "sr1 no hold after early drop", cap_sr1, 24, 37);
    // comparator low throughout: nominal window, never earlier
    capture(-1, -1);
    win("R6", "sr2 cmp low throughout", cap_sr2, 1, 14);
  endtask

  task automatic t_enables();
    base_cfg(); bridge_en = 1'b0;
    capture(-1, -1);
    win("R8", "hs bridge off", cap_hs, 0, 0);
    win("R8", "ls bridge off", cap_ls, 0, 0);
    win("R8", "sr2 stays with bridge off", cap_sr2, 1, 18);
    base_cfg(); rect_en = 1'b0;
    capture(-1, -1);
    win("R8", "sr1 rect off", cap_sr1, 0, 0);
    win("R8", "sr2 rect off", cap_sr2, 0, 0);
    win("R8", "ls stays with rect off", cap_ls, 23, 40);
  endtask

  task automatic t_midchange();
    base_cfg();
    capture(-1, -1);
    capture(-1, 5);
    check("R9", "length after mid change", cap_len, 40);
    win("R9", "hs after mid change", cap_hs, 2, 20);
    capture(-1, -1);
    check("R9", "new period length", cap_len, 50);
    win("R9", "hs new delay", cap_hs, 7, 25);
  endtask

  task automatic t_clamp();
    base_cfg(); period = 12'd3;
    capture(-1, -1);
    check("R11", "clamped length", cap_len, 8);
    win("R11", "hs clamped", cap_hs, 2, 4);
    win("R11", "ls clamped", cap_ls, 7, 8);
    win("R11", "sr1 clamped", cap_sr1, 0, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog (all): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    t_reset();
    t_basic();
    t_odd();
    t_cmp_ignored();
    t_cmp_hold();
    t_cmp_drop();
    t_enables();
    t_midchange();
    t_clamp();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule